// File: doc/BRIEF.md
# Ethernet receive address filter

This block sits on the receive path and decides, frame by frame, whether the destination address of an arriving Ethernet frame is wanted. The first six bytes of each frame (the destination address) arrive one per cycle, qualified by a valid strobe, with a start-of-frame strobe on the first byte. The block sorts the address into broadcast, multicast or unicast. It compares the address with a programmed station address, and looks it up in a 64-entry accept table. The table is indexed by six bits of a CRC-32 taken over the address alone.

Six acceptance classes can be switched on one at a time. The accept decision is the OR of the enabled classes that match, and a pass-all control forces acceptance. The decision and the class flags appear as a one-cycle result strobe on the cycle after the sixth byte. A set of sticky status bits records which classes matched. Software clears those bits by writing ones through the same small configuration port that loads the station address, the table and the controls.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, dec_vld, dec_accept, all class flags and wake_stat are 0. The control word is 0, so a frame that arrives before any configuration is rejected.
- R2: On each result, exactly one class flag is set. The address is broadcast when all 48 bits are 1. Otherwise it is multicast when bit 0 of the first received byte is 1. Any other address is unicast.
- R3: dec_vld is a one-cycle pulse in the cycle after the sixth byte of an address that began with rx_sof. The following bytes are ignored until the next rx_sof and produce no further result. Bytes received without a preceding rx_sof are ignored in the same way.
- R4: The station address is written as three 16-bit words in cfg_data[15:0]. Selector 0 takes {byte5, byte4}, selector 1 takes {byte3, byte2} and selector 2 takes {byte1, byte0}, where byte0 is the first byte received. The perfect-match class matches only when all six bytes are equal.
- R5: The hash index is bits [28:23] of a CRC-32 over the six address bytes. The CRC uses generator 0x04C11DB7, starts from all ones, takes the low nibble of each byte first, and pairs data bit 0 of each nibble with CRC bit 31. Table selector 5 holds indices 0 to 31 (bit n is index n) and selector 6 holds indices 32 to 63. A hash class matches only when the addressed table bit is 1.
- R6: Control selector 3 bits [5:0] enable these classes: [0] every unicast, [1] broadcast, [2] every multicast, [3] unicast through the table, [4] multicast through the table, [5] perfect match. The accept output is the OR of the enabled matches.
- R7: Control bit 6 (pass-all) makes every result an accept and leaves the status bits unchanged.
- R8: wake_stat uses the bit positions of R6. A bit is set when its class matches and stays set until it is cleared.
- R9: Writing selector 4 clears each wake_stat bit whose cfg_data bit is 1 and leaves the others alone. If a clear and a new match of the same bit fall in the same cycle, the bit stays set.
- R10: An rx_sof that arrives part way through an address restarts capture and the CRC. Only the restarted address produces a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration selector (0-2 station, 3 control, 4 status clear, 5-6 table) |
| cfg_data | input | 32 | Configuration write data |
| rx_vld | input | 1 | Address byte valid |
| rx_sof | input | 1 | First byte of a frame, qualified by rx_vld |
| rx_byte | input | 8 | Address byte |
| dec_vld | output | 1 | Result strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_ucast | output | 1 | Destination is unicast |
| dec_mcast | output | 1 | Destination is multicast (not broadcast) |
| dec_bcast | output | 1 | Destination is broadcast |
| wake_stat | output | 6 | Sticky per-class match status |

## Verification
Two functions can act on the same status bit in the same cycle. One is the class match, which sets a bit as the sixth address byte is taken. The other is the write-one-to-clear of that bit through selector 4. The bench provokes this by driving the clear write on the same cycle as the sixth byte of a broadcast frame, while a second bit that nothing sets is also set. It then expects the matched bit to survive and the unmatched bit to be gone.

// File: rtl/afilt_pkg.sv
`timescale 1ns/1ps
package afilt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int N_CLS      = 6;
  localparam int CRC_TOP    = 28;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  // class bit positions, shared by enables and status
  localparam int C_UALL  = 0;
  localparam int C_BCAST = 1;
  localparam int C_MALL  = 2;
  localparam int C_UHASH = 3;
  localparam int C_MHASH = 4;
  localparam int C_PERF  = 5;
  localparam int PASS_BIT = 6;

  // configuration selectors
  localparam int SEL_STA0 = 0;
  localparam int SEL_CTRL = 3;
  localparam int SEL_WCLR = 4;
  localparam int SEL_HASH = 5;

  // one nibble through the CRC: the top four CRC bits meet the nibble bits
  // in reverse order and the resulting 4-bit pattern picks shifted generators
  function automatic logic [31:0] crc_nibble(input logic [31:0] c, input logic [3:0] d);
    logic [3:0]  t;
    logic [31:0] r;
    t = {c[31] ^ d[0], c[30] ^ d[1], c[29] ^ d[2], c[28] ^ d[3]};
    r = {c[27:0], 4'h0};
    for (int k = 0; k < 4; k++)
      if (t[k]) r = r ^ (CRC_POLY << k);
    return r;
  endfunction

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    return crc_nibble(crc_nibble(c, b[3:0]), b[7:4]);
  endfunction
endpackage

// File: rtl/afilt_crc.sv
`timescale 1ns/1ps
module afilt_crc import afilt_pkg::*; #(
  parameter int HASH_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              restart,
  input  logic [7:0]        din,
  output logic [HASH_W-1:0] hash_idx
);
  logic [31:0] crc_q;
  logic [31:0] crc_next;

  assign crc_next = crc_byte(restart ? 32'hFFFF_FFFF : crc_q, din);
  assign hash_idx = crc_next[CRC_TOP -: HASH_W];

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= 32'hFFFF_FFFF;
    else if (take) crc_q <= crc_next;
  end

  // R3: bytes that are not taken leave the running CRC alone
  assert_crc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(crc_q));
endmodule

// File: rtl/afilt_cfg.sv
`timescale 1ns/1ps
module afilt_cfg import afilt_pkg::*; #(
  parameter int HASH_W = 6,
  parameter int SEL_W  = 4,
  parameter int DW     = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_wr,
  input  logic [SEL_W-1:0]       cfg_sel,
  input  logic [DW-1:0]          cfg_data,
  output logic [8*ADDR_BYTES-1:0] station,
  output logic [(1<<HASH_W)-1:0] table_bits,
  output logic [N_CLS-1:0]       cls_en,
  output logic                   pass_all,
  output logic [N_CLS-1:0]       stat_clr
);
  localparam int TBL_BITS = 1 << HASH_W;
  localparam int WORDS    = TBL_BITS / DW;

  logic [15:0]   sta_w [3];
  logic [DW-1:0] tbl   [WORDS];
  logic [N_CLS:0] ctrl_q;
  logic [SEL_W-1:0] hoff;

  assign hoff = cfg_sel - SEL_W'(SEL_HASH);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) sta_w[i] <= '0;
      ctrl_q <= '0;
    end else if (cfg_wr) begin
      for (int i = 0; i < 3; i++)
        if (cfg_sel == SEL_W'(SEL_STA0 + i)) sta_w[i] <= cfg_data[15:0];
      if (cfg_sel == SEL_W'(SEL_CTRL)) ctrl_q <= cfg_data[N_CLS:0];
    end
  end

  // accept table: plain write-only-by-port memory, no reset
  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++)
      if (cfg_wr && hoff == SEL_W'(w)) tbl[w] <= cfg_data;
  end

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_tbl
      assign table_bits[w*DW +: DW] = tbl[w];
    end
  endgenerate

  // first received byte sits in the most significant byte of station
  assign station  = {sta_w[2][7:0], sta_w[2][15:8], sta_w[1][7:0], sta_w[1][15:8],
                     sta_w[0][7:0], sta_w[0][15:8]};
  assign cls_en   = ctrl_q[N_CLS-1:0];
  assign pass_all = ctrl_q[PASS_BIT];
  assign stat_clr = (cfg_wr && cfg_sel == SEL_W'(SEL_WCLR)) ? cfg_data[N_CLS-1:0] : '0;
endmodule

// File: rtl/afilt_decide.sv
`timescale 1ns/1ps
module afilt_decide import afilt_pkg::*; #(
  parameter int HASH_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    last,
  input  logic [8*ADDR_BYTES-1:0] dest,
  input  logic [8*ADDR_BYTES-1:0] station,
  input  logic [(1<<HASH_W)-1:0]  table_bits,
  input  logic [HASH_W-1:0]       hash_idx,
  input  logic [N_CLS-1:0]        cls_en,
  input  logic                    pass_all,
  output logic [N_CLS-1:0]        hits,
  output logic                    dec_vld,
  output logic                    dec_accept,
  output logic                    dec_ucast,
  output logic                    dec_mcast,
  output logic                    dec_bcast
);
  localparam int GRP_BIT = 8*ADDR_BYTES - 8;  // bit 0 of first byte

  logic is_b, is_m, is_u, tbl_hit;
  logic [N_CLS-1:0] m;

  always_comb begin
    is_b    = &dest;
    is_m    = dest[GRP_BIT] & ~is_b;
    is_u    = ~dest[GRP_BIT];
    tbl_hit = table_bits[hash_idx];
    m[C_UALL]  = cls_en[C_UALL]  & is_u;
    m[C_BCAST] = cls_en[C_BCAST] & is_b;
    m[C_MALL]  = cls_en[C_MALL]  & is_m;
    m[C_UHASH] = cls_en[C_UHASH] & is_u & tbl_hit;
    m[C_MHASH] = cls_en[C_MHASH] & is_m & tbl_hit;
    m[C_PERF]  = cls_en[C_PERF]  & (dest == station);
  end

  assign hits = last ? m : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_vld    <= 1'b0;
      dec_accept <= 1'b0;
      dec_ucast  <= 1'b0;
      dec_mcast  <= 1'b0;
      dec_bcast  <= 1'b0;
    end else begin
      dec_vld <= last;
      if (last) begin
        dec_accept <= pass_all | (|m);
        dec_ucast  <= is_u;
        dec_mcast  <= is_m;
        dec_bcast  <= is_b;
      end
    end
  end

  assert_class_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    dec_vld |-> $countones({dec_ucast, dec_mcast, dec_bcast}) == 1);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    dec_vld |=> !dec_vld);

  assert_pass_all_R7: assert property (@(posedge clk) disable iff (rst)
    (last && pass_all) |=> (dec_vld && dec_accept));
endmodule

// File: rtl/afilt_status.sv
`timescale 1ns/1ps
module afilt_status import afilt_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CLS-1:0] set,
  input  logic [N_CLS-1:0] clr,
  output logic [N_CLS-1:0] stat
);
  // a new match outranks a clear of the same bit
  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (stat & ~clr) | set;
  end

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((($past(stat) & ~$past(clr)) & ~stat) == '0));

  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (|(clr & ~set)) |=> ((stat & $past(clr & ~set)) == '0));
endmodule

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
module rx_addr_filter import afilt_pkg::*; #(
  parameter int HASH_W = 6,
  parameter int SEL_W  = 4,
  parameter int DW     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [DW-1:0]    cfg_data,
  input  logic             rx_vld,
  input  logic             rx_sof,
  input  logic [7:0]       rx_byte,
  output logic             dec_vld,
  output logic             dec_accept,
  output logic             dec_ucast,
  output logic             dec_mcast,
  output logic             dec_bcast,
  output logic [N_CLS-1:0] wake_stat
);
  localparam int CW = $clog2(ADDR_BYTES + 1);

  logic [CW-1:0] cnt;
  logic [7:0]    addr_q [ADDR_BYTES];
  logic          active, last, take;
  logic [8*ADDR_BYTES-1:0] dest_now, station;
  logic [(1<<HASH_W)-1:0]  table_bits;
  logic [HASH_W-1:0]       hash_idx;
  logic [N_CLS-1:0]        cls_en, stat_clr, hits;
  logic                    pass_all;

  assign active = cnt < CW'(ADDR_BYTES);
  assign take   = rx_vld && (rx_sof || active);
  assign last   = rx_vld && !rx_sof && (cnt == CW'(ADDR_BYTES - 1));

  // idle count of ADDR_BYTES means: wait for the next start of frame
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CW'(ADDR_BYTES);
      for (int i = 0; i < ADDR_BYTES; i++) addr_q[i] <= '0;
    end else if (rx_vld && rx_sof) begin
      addr_q[0] <= rx_byte;
      cnt <= CW'(1);
    end else if (rx_vld && active) begin
      for (int i = 0; i < ADDR_BYTES; i++)
        if (cnt == CW'(i)) addr_q[i] <= rx_byte;
      cnt <= cnt + CW'(1);
    end
  end

  generate
    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_dest
      if (i == ADDR_BYTES - 1) begin : g_live
        assign dest_now[8*(ADDR_BYTES-1-i) +: 8] = rx_byte;
      end else begin : g_held
        assign dest_now[8*(ADDR_BYTES-1-i) +: 8] = addr_q[i];
      end
    end
  endgenerate

  afilt_cfg #(.HASH_W(HASH_W), .SEL_W(SEL_W), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .station(station), .table_bits(table_bits), .cls_en(cls_en),
    .pass_all(pass_all), .stat_clr(stat_clr));

  afilt_crc #(.HASH_W(HASH_W)) u_crc (
    .clk(clk), .rst(rst), .take(take), .restart(rx_sof), .din(rx_byte),
    .hash_idx(hash_idx));

  afilt_decide #(.HASH_W(HASH_W)) u_dec (
    .clk(clk), .rst(rst), .last(last), .dest(dest_now), .station(station),
    .table_bits(table_bits), .hash_idx(hash_idx), .cls_en(cls_en),
    .pass_all(pass_all), .hits(hits), .dec_vld(dec_vld), .dec_accept(dec_accept),
    .dec_ucast(dec_ucast), .dec_mcast(dec_mcast), .dec_bcast(dec_bcast));

  afilt_status u_stat (
    .clk(clk), .rst(rst), .set(hits), .clr(stat_clr), .stat(wake_stat));
endmodule

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic        rx_vld = 1'b0, rx_sof = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        dec_vld, dec_accept, dec_ucast, dec_mcast, dec_bcast;
  logic [5:0]  wake_stat;

  int n_chk = 0, n_bad = 0, pulses = 0;

  logic [47:0] sh_sta = '0;
  logic [63:0] sh_tbl = '0;
  logic [5:0]  sh_en = '0, sh_stat = '0;
  logic        sh_pass = 1'b0;

  always #4 clk = ~clk;

  rx_addr_filter u0 (.clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_byte(rx_byte),
    .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_ucast(dec_ucast),
    .dec_mcast(dec_mcast), .dec_bcast(dec_bcast), .wake_stat(wake_stat));

  always @(negedge clk) if (!rst && dec_vld) pulses++;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bit-at-a-time CRC, data bit 0 first, against CRC bit 31
  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  b;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      b = a[47-8*i -: 8];
      for (int k = 0; k < 8; k++) begin
        fb = c[31] ^ b[k];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    end
    return c[28:23];
  endfunction

  function automatic logic [2:0] ref_cls(input logic [47:0] a);  // {u,m,b}
    logic b;
    b = &a;
    return {~a[40], a[40] & ~b, b};
  endfunction

  function automatic logic [5:0] ref_match(input logic [47:0] a);
    logic [2:0] c;
    logic hit;
    c = ref_cls(a);
    hit = sh_tbl[ref_idx(a)];
    return {sh_en[5] & (a == sh_sta), sh_en[4] & c[1] & hit, sh_en[3] & c[2] & hit,
            sh_en[2] & c[1], sh_en[1] & c[0], sh_en[0] & c[2]};
  endfunction

  task automatic wr_cfg(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_ctrl(input logic [5:0] en, input logic pass);
    sh_en = en; sh_pass = pass;
    wr_cfg(4'd3, {25'd0, pass, en});
  endtask

  task automatic set_table(input logic [63:0] t);
    sh_tbl = t;
    wr_cfg(4'd5, t[31:0]);
    wr_cfg(4'd6, t[63:32]);
  endtask

  task automatic set_station(input logic [47:0] a);
    sh_sta = a;
    wr_cfg(4'd0, {16'd0, a[7:0], a[15:8]});
    wr_cfg(4'd1, {16'd0, a[23:16], a[31:24]});
    wr_cfg(4'd2, {16'd0, a[39:32], a[47:40]});
  endtask

  task automatic put_byte(input logic [7:0] b, input logic sof);
    @(negedge clk);
    rx_vld = 1'b1; rx_sof = sof; rx_byte = b;
  endtask

  task automatic send_addr(input logic [47:0] a, input logic [5:0] clr);
    for (int i = 0; i < 6; i++) begin
      put_byte(a[47-8*i -: 8], i == 0);
      if (i == 5 && clr != 0) begin
        cfg_wr = 1'b1; cfg_sel = 4'd4; cfg_data = {26'd0, clr};
      end
    end
    @(negedge clk);
    rx_vld = 1'b0; rx_sof = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic check_frame(input string req, input logic [47:0] a, input logic [5:0] clr);
    logic [5:0] m;
    m = ref_match(a);
    send_addr(a, clr);
    sh_stat = (sh_stat & ~clr) | m;
    check({req, " result strobe"}, dec_vld, 1);
    check({req, " accept"}, dec_accept, sh_pass | (|m));
    check({req, " class flags"}, {dec_ucast, dec_mcast, dec_bcast}, ref_cls(a));
    check({req, " status"}, wake_stat, sh_stat);
  endtask

  localparam logic [47:0] UC = 48'h00_10_20_30_40_50;
  localparam logic [47:0] MC = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] BC = 48'hFF_FF_FF_FF_FF_FF;

  task automatic t_reset;
    check("R1 dec_vld after reset", dec_vld, 0);
    check("R1 accept after reset", dec_accept, 0);
    check("R1 flags after reset", {dec_ucast, dec_mcast, dec_bcast}, 0);
    check("R1 status after reset", wake_stat, 0);
    check_frame("R1 unconfigured frame", UC, 0);
  endtask

  task automatic t_class;
    set_ctrl(6'b000001, 0);
    check_frame("R6 all-unicast on unicast", UC, 0);
    check_frame("R2 multicast classified", MC, 0);
    check_frame("R2 broadcast classified", BC, 0);
    set_ctrl(6'b000100, 0);
    check_frame("R6 all-multicast on multicast", MC, 0);
    check_frame("R2 broadcast not multicast", BC, 0);
    set_ctrl(6'b000010, 0);
    check_frame("R6 broadcast class", BC, 0);
    check_frame("R6 broadcast class on unicast", UC, 0);
  endtask

  task automatic t_perfect;
    set_station(48'h02_A1_B2_C3_D4_E5);
    set_ctrl(6'b100000, 0);
    check_frame("R4 exact station", 48'h02_A1_B2_C3_D4_E5, 0);
    check_frame("R4 last byte differs", 48'h02_A1_B2_C3_D4_E4, 0);
    check_frame("R4 first byte differs", 48'h06_A1_B2_C3_D4_E5, 0);
    check_frame("R4 middle byte differs", 48'h02_A1_B3_C3_D4_E5, 0);
  endtask

  task automatic t_hash;
    logic [47:0] u_lo, u_hi, m_any, a;
    logic        got_lo, got_hi;
    logic [5:0]  ix;
    got_lo = 0; got_hi = 0;
    u_lo = UC; u_hi = UC;
    for (int k = 0; k < 256; k++) begin
      a = {40'h02_11_22_33_44, k[7:0]};
      ix = ref_idx(a);
      if (!got_lo && ix < 32) begin u_lo = a; got_lo = 1; end
      if (!got_hi && ix >= 32) begin u_hi = a; got_hi = 1; end
    end
    m_any = 48'h01_00_5E_7F_00_2A;
    set_ctrl(6'b011000, 0);
    set_table(64'd1 << ref_idx(u_lo));
    check_frame("R5 unicast hash low word hit", u_lo, 0);
    set_table(64'd1 << ref_idx(u_hi));
    check_frame("R5 unicast hash high word hit", u_hi, 0);
    set_table(~(64'd1 << ref_idx(u_hi)));
    check_frame("R5 unicast hash bit clear", u_hi, 0);
    set_table(64'd1 << ref_idx(m_any));
    check_frame("R5 multicast hash hit", m_any, 0);
    set_ctrl(6'b001000, 0);
    check_frame("R6 multicast hash disabled", m_any, 0);
  endtask

  task automatic t_pass;
    set_ctrl(6'b000000, 1);
    check_frame("R7 pass-all unicast", UC, 0);
    check_frame("R7 pass-all multicast", MC, 0);
    set_ctrl(6'b000000, 0);
    check_frame("R7 pass-all removed", UC, 0);
  endtask

  task automatic t_status;
    wr_cfg(4'd4, 32'h3F);
    sh_stat = '0;
    check("R9 clear all", wake_stat, 0);
    set_ctrl(6'b000011, 0);
    check_frame("R8 set by unicast", UC, 0);
    check_frame("R8 set by broadcast", BC, 0);
    check_frame("R8 held across rejected frame", MC, 0);
    wr_cfg(4'd4, 32'h01);
    sh_stat = sh_stat & ~6'h01;
    check("R9 clear one bit", wake_stat, sh_stat);
    check_frame("R8 set again", UC, 0);
    check_frame("R9 clear and match same cycle", BC, 6'h3F);
  endtask

  task automatic t_timing;
    int p0;
    set_ctrl(6'b000001, 0);
    check_frame("R3 frame", UC, 0);
    @(negedge clk);
    check("R3 strobe lasts one cycle", dec_vld, 0);
    @(negedge clk);
    p0 = pulses;
    put_byte(8'h00, 1); put_byte(8'h01, 0); put_byte(8'h02, 0);
    put_byte(8'h03, 0); put_byte(8'h04, 0); put_byte(8'h05, 0);
    put_byte(8'h06, 0); put_byte(8'h07, 0); put_byte(8'h08, 0);
    @(negedge clk); rx_vld = 0; rx_sof = 0;
    repeat (2) @(negedge clk);
    check("R3 trailing bytes ignored", pulses - p0, 1);
    p0 = pulses;
    for (int i = 0; i < 6; i++) put_byte(8'h10 + 8'(i), 0);
    @(negedge clk); rx_vld = 0;
    repeat (2) @(negedge clk);
    check("R3 bytes without start ignored", pulses - p0, 0);
    p0 = pulses;
    put_byte(8'hFF, 1); put_byte(8'hFF, 0); put_byte(8'hFF, 0);
    check_frame("R10 restart mid-address", UC, 0);
    repeat (2) @(negedge clk);
    check("R10 single result after restart", pulses - p0, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_class;
    t_perfect;
    t_hash;
    t_pass;
    t_status;
    t_timing;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule